// File: doc/BRIEF.md
# Bit-Serial Doubleword Request Master

This block issues one doubleword read or write at a time to a memory target across a single serial data wire and a separate valid strobe. A parallel command port supplies the operation, a 40-bit physical address and, for writes, a 64-bit data word. The block forms a 64-bit request header and sends it one bit per clock, least significant bit first. For a write, the data word follows immediately. The block then waits for the target to reply on its own return strobe and data wire.

For a read, the 64 returned bits are assembled into a word. The word is presented with a one-cycle done pulse. For a write, the returned packet counts only as an acknowledge, and done is pulsed once the packet has passed. Only one request is in flight at a time. `busy` tells the requester when a new command will be taken. An address that is not 8-byte aligned sets a flag, but the request still goes out exactly as given.

The controller is a six-state machine:
- ST_IDLE goes to ST_HDR when a command is accepted.
- ST_HDR goes to ST_DAT after the last header bit of a write, or to ST_WAIT after the last header bit of a read.
- ST_DAT goes to ST_WAIT after the last data bit.
- ST_WAIT goes to ST_RECV when a return strobe is seen.
- ST_RECV goes to ST_DONE after the last returned bit.
- ST_DONE always returns to ST_IDLE.

Top module: `serial_mem_master`

## Requirements
- R1: A synchronous active-low reset puts the block in ST_IDLE. After the reset edge, `busy`, `done`, `ser_vld_o`, `ser_data_o`, `misalign_err` and `rd_data` all read 0.
- R2: The request header has its address in bits [39:0] and zeros in bits [55:40]. Bits [63:56] hold the opcode: 0x81 for a read, 0x82 for a write.
- R3: When `cmd_valid` is high and `busy` is low at a clock edge, the command is accepted. Bit 0 of the header appears on `ser_data_o` in the cycle right after that edge. Header bit i appears i cycles later, so the word goes out least significant bit first over 64 consecutive cycles.
- R4: `ser_vld_o` is high for exactly one cycle per word, in the cycle that carries bit 0. A write sends the header and then the data word back to back, 128 cycles in all, with the strobe at cycles 0 and 64. A read sends the header alone.
- R5: `ser_data_o` is 0 in every cycle in which no header or data bit is being sent.
- R6: A response is recognised only after the request has been sent in full. The cycle in which `rsp_vld_i` is high carries returned bit 0 on `rsp_data_i`, and the next 63 cycles carry bits 1 to 63. A `rsp_vld_i` pulse while idle or while sending has no effect.
- R7: For a read, `done` is high for one cycle, in the cycle after returned bit 63 is sampled. In that cycle `rd_data` holds the assembled word, and it keeps that value until the next read completes.
- R8: For a write, `done` pulses one cycle after the last bit of the 64-cycle acknowledge packet. The packet's content is ignored, and `rd_data` keeps its previous value.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle, and low in the cycle after. A `cmd_valid` seen while `busy` is high is ignored.
- R10: At acceptance, `misalign_err` is loaded with 1 if address bits [2:0] are nonzero and 0 otherwise. It holds that value until the next acceptance. The request is sent unchanged either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request; accepted when `busy` is low |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Physical address |
| cmd_wdata | input | WORD_W | Write data |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | WORD_W | Last read word returned |
| misalign_err | output | 1 | Address of the current or last request was not 8-byte aligned |
| ser_vld_o | output | 1 | Outgoing word strobe |
| ser_data_o | output | 1 | Outgoing serial data |
| rsp_vld_i | input | 1 | Return word strobe |
| rsp_data_i | input | 1 | Return serial data |

## Verification
The bench sends return strobes and new commands while the header is still being sent. A design that listened too early would finish ahead of time or restart mid-request. The earliest legal response is tested: a strobe in the first cycle of ST_WAIT. A strobe one cycle early would be lost, and a design that was late entering ST_WAIT would hang. Back-to-back commands issued just after `done` test that `busy` drops in the right cycle and that the line stays low between requests. A write reply with random content is used, and the bench checks that `rd_data` does not change, which would otherwise be corrupted by the acknowledge. A reset in the middle of a write must leave both outgoing wires low at once, not after the request drains.

// File: rtl/smm_pkg.sv
package smm_pkg;
    localparam int OPC_W = 8;
    localparam logic [OPC_W-1:0] OPC_READ  = 8'h81;
    localparam logic [OPC_W-1:0] OPC_WRITE = 8'h82;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DAT,
        ST_WAIT,
        ST_RECV,
        ST_DONE
    } smm_state_e;
endpackage

// File: rtl/smm_hdr_build.sv
module smm_hdr_build #(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 40
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] hdr
);
    localparam int RSVD_W = WORD_W - smm_pkg::OPC_W - ADDR_W;

    always_comb begin
        hdr = {(is_write ? smm_pkg::OPC_WRITE : smm_pkg::OPC_READ),
               {RSVD_W{1'b0}}, addr};
    end
endmodule

// File: rtl/smm_tx_shifter.sv
module smm_tx_shifter #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    output logic              bit_o
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[WORD_W-1:1]};
        end
    end

    assign bit_o = sr_q[0];
endmodule

// File: rtl/smm_bit_counter.sv
module smm_bit_counter #(
    parameter int WORD_W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_zero,
    output logic at_last
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);
    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/smm_rx_deser.sv
module smm_rx_deser #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              commit,
    input  logic              din,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_nxt;

    assign sr_nxt = {din, sr_q[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            word_o <= '0;
        end else begin
            if (shift) begin
                sr_q <= sr_nxt;
            end
            if (commit) begin
                word_o <= sr_nxt;
            end
        end
    end
endmodule

// File: rtl/serial_mem_master.sv
module serial_mem_master #(
    parameter int WORD_W     = 64,
    parameter int ADDR_W     = 40,
    parameter int ALIGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              misalign_err,
    output logic              ser_vld_o,
    output logic              ser_data_o,
    input  logic              rsp_vld_i,
    input  logic              rsp_data_i
);
    import smm_pkg::*;

    smm_state_e state_q, state_nxt;

    logic              wr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              misalign_q;

    logic              accept;
    logic              tx_load, tx_sel_data, tx_shift, tx_active, tx_bit;
    logic              cnt_clr, cnt_inc, cnt_zero, cnt_last;
    logic              rx_shift, rx_commit;
    logic [WORD_W-1:0] hdr;
    logic [WORD_W-1:0] tx_load_val;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_nxt = ST_HDR;
            ST_HDR:  if (cnt_last)  state_nxt = wr_q ? ST_DAT : ST_WAIT;
            ST_DAT:  if (cnt_last)  state_nxt = ST_WAIT;
            ST_WAIT: if (rsp_vld_i) state_nxt = ST_RECV;
            ST_RECV: if (cnt_last)  state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Per-state controls and outputs
    always_comb begin
        accept      = 1'b0;
        tx_load     = 1'b0;
        tx_sel_data = 1'b0;
        tx_shift    = 1'b0;
        tx_active   = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        rx_shift    = 1'b0;
        rx_commit   = 1'b0;
        done        = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (cmd_valid) begin
                    accept  = 1'b1;
                    tx_load = 1'b1;
                    cnt_clr = 1'b1;
                end
            end
            ST_HDR: begin
                tx_active = 1'b1;
                tx_shift  = 1'b1;
                if (cnt_last) begin
                    cnt_clr = 1'b1;
                    if (wr_q) begin
                        tx_load     = 1'b1;
                        tx_sel_data = 1'b1;
                    end
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DAT: begin
                tx_active = 1'b1;
                tx_shift  = 1'b1;
                if (cnt_last) cnt_clr = 1'b1;
                else          cnt_inc = 1'b1;
            end
            ST_WAIT: begin
                if (rsp_vld_i) begin
                    rx_shift = 1'b1;
                    cnt_inc  = 1'b1;
                end
            end
            ST_RECV: begin
                rx_shift = 1'b1;
                if (cnt_last) begin
                    cnt_clr   = 1'b1;
                    rx_commit = !wr_q;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign ser_vld_o    = tx_active && cnt_zero;
    assign ser_data_o   = tx_active && tx_bit;
    assign misalign_err = misalign_q;

    // Request context captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            misalign_q <= 1'b0;
        end else if (accept) begin
            wr_q       <= cmd_write;
            wdata_q    <= cmd_wdata;
            misalign_q <= |cmd_addr[ALIGN_BITS-1:0];
        end
    end

    assign tx_load_val = tx_sel_data ? wdata_q : hdr;

    smm_hdr_build #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) hdr_i (
        .is_write (cmd_write),
        .addr     (cmd_addr),
        .hdr      (hdr)
    );

    smm_tx_shifter #(.WORD_W(WORD_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_load_val),
        .shift    (tx_shift),
        .bit_o    (tx_bit)
    );

    smm_bit_counter #(.WORD_W(WORD_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .at_zero (cnt_zero),
        .at_last (cnt_last)
    );

    smm_rx_deser #(.WORD_W(WORD_W)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (rx_shift),
        .commit (rx_commit),
        .din    (rsp_data_i),
        .word_o (rd_data)
    );
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
    parameter int WORD_W     = 64,
    parameter int ADDR_W     = 40,
    parameter int ALIGN_BITS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              busy,
    input logic              done,
    input logic              misalign_err,
    input logic              ser_vld_o,
    input logic              ser_data_o
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (ser_vld_o) begin
            gap_q  <= 16'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 16'd1;
        end
    end

    // R5
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_data_o && !ser_vld_o));

    // R4
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld_o |=> !ser_vld_o);

    // R4
    vld_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_vld_o && seen_q) |-> (gap_q == 16'(WORD_W)));

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && !done));

    // R10
    misalign_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (misalign_err == $past(|cmd_addr[ALIGN_BITS-1:0])));

    // R10
    misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(misalign_err));
endmodule

bind serial_mem_master smm_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_addr     (cmd_addr),
    .busy         (busy),
    .done         (done),
    .misalign_err (misalign_err),
    .ser_vld_o    (ser_vld_o),
    .ser_data_o   (ser_data_o)
);

// File: tb/serial_mem_master_tb_top.sv
`timescale 1ns/1ps
module serial_mem_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [39:0] cmd_addr = '0;
    logic [63:0] cmd_wdata = '0;
    logic        busy, done, misalign_err, ser_vld_o, ser_data_o;
    logic [63:0] rd_data;
    logic        rsp_vld_i = 1'b0;
    logic        rsp_data_i = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_mem_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .misalign_err(misalign_err), .ser_vld_o(ser_vld_o),
        .ser_data_o(ser_data_o), .rsp_vld_i(rsp_vld_i), .rsp_data_i(rsp_data_i)
    );

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 sending, 2 waiting, 3 receiving, 4 done
    bit          m_vq[$];
    bit          m_dq[$];
    int          m_state = 0;
    int          m_cnt = 0;
    logic [63:0] m_rx = '0;
    logic [63:0] m_rd = '0;
    bit          m_mis = 1'b0;
    bit          m_wr = 1'b0;

    always @(negedge clk) begin
        if (!finished) begin
            check_val("R9 busy", busy, (m_state != 0));
            check_val("R4 ser_vld_o", ser_vld_o, (m_state == 1) ? m_vq[0] : 1'b0);
            check_val("R2 R3 R5 ser_data_o", ser_data_o, (m_state == 1) ? m_dq[0] : 1'b0);
            check_val("R6 R7 R8 done", done, (m_state == 4));
            check_val("R7 R8 rd_data", rd_data, m_rd);
            check_val("R10 misalign_err", misalign_err, m_mis);
            if (!rst_n) begin
                m_state = 0; m_vq.delete(); m_dq.delete();
                m_rd = '0; m_mis = 0; m_wr = 0; m_cnt = 0;
            end else begin
                case (m_state)
                    0: if (cmd_valid) begin
                        logic [63:0] h;
                        h = {(cmd_write ? 8'h82 : 8'h81), 16'h0, cmd_addr};
                        for (int i = 0; i < 64; i++) begin
                            m_vq.push_back(i == 0); m_dq.push_back(h[i]);
                        end
                        if (cmd_write)
                            for (int i = 0; i < 64; i++) begin
                                m_vq.push_back(i == 0); m_dq.push_back(cmd_wdata[i]);
                            end
                        m_wr = cmd_write;
                        m_mis = (cmd_addr[2:0] != 3'b0);
                        m_state = 1;
                    end
                    1: begin
                        void'(m_vq.pop_front()); void'(m_dq.pop_front());
                        if (m_vq.size() == 0) m_state = 2;
                    end
                    2: if (rsp_vld_i) begin
                        m_rx[0] = rsp_data_i; m_cnt = 1; m_state = 3;
                    end
                    3: begin
                        m_rx[m_cnt] = rsp_data_i; m_cnt++;
                        if (m_cnt == 64) begin
                            if (!m_wr) m_rd = m_rx;
                            m_state = 4;
                        end
                    end
                    default: m_state = 0;
                endcase
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_cmd(input bit wr, input logic [39:0] a, input logic [63:0] d);
        step();
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        step();
        cmd_valid = 1'b0; cmd_wdata = '0;
    endtask

    task automatic respond(input logic [63:0] w, input int dly);
        repeat (dly) step();
        rsp_vld_i = 1'b1; rsp_data_i = w[0];
        for (int i = 1; i < 64; i++) begin
            step();
            rsp_vld_i = 1'b0; rsp_data_i = w[i];
        end
        step();
        rsp_data_i = 1'b0;
    endtask

    task automatic wait_done_pulse();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [63:0] w1, w2, w3;
        w1 = 64'hDEAD_BEEF_0123_4567;
        w2 = 64'h5A5A_F00D_C3C3_0F0F;
        w3 = 64'h8000_0000_0000_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs after reset edge
        check_val("R1 busy", busy, 0);
        check_val("R1 ser_vld_o", ser_vld_o, 0);
        check_val("R1 ser_data_o", ser_data_o, 0);
        check_val("R1 rd_data", rd_data, 0);
        step();
        rst_n = 1'b1;

        // Read, aligned, with stray strobe and command during the header (R6, R9)
        send_cmd(1'b0, 40'h12_3456_7898, 64'h0);
        repeat (10) step();
        rsp_vld_i = 1'b1; rsp_data_i = 1'b1;
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 40'h7;
        step();
        rsp_vld_i = 1'b0; rsp_data_i = 1'b0; cmd_valid = 1'b0;
        respond(w1, 60);
        wait_done_pulse();
        check_val("R7 read word", rd_data, w1);
        check_val("R10 aligned flag", misalign_err, 0);

        // Write, misaligned; acknowledge content ignored (R8, R10)
        step();
        send_cmd(1'b1, 40'hAB_CDEF_0125, w2);
        respond(64'hFFFF_0000_1234_ABCD, 140);
        wait_done_pulse();
        check_val("R8 rd_data kept", rd_data, w1);
        check_val("R10 misaligned flag", misalign_err, 1);

        // Back-to-back read with earliest legal response (R6, R9)
        @(negedge clk);
        check_val("R9 busy low after done", busy, 0);
        send_cmd(1'b0, 40'h00_0000_0040, 64'h0);
        respond(w3, 64);
        wait_done_pulse();
        check_val("R6 R7 earliest response word", rd_data, w3);

        // Reset in the middle of a write (R1)
        step();
        send_cmd(1'b1, 40'h01_0000_0003, w2);
        repeat (30) step();
        rst_n = 1'b0;
        step();
        @(negedge clk);
        check_val("R1 mid-write busy", busy, 0);
        check_val("R1 mid-write ser_data_o", ser_data_o, 0);
        check_val("R1 mid-write misalign_err", misalign_err, 0);
        step();
        rst_n = 1'b1;

        // Recovery read (R3)
        send_cmd(1'b0, 40'hFF_FFFF_FFF8, 64'h0);
        respond(w2, 70);
        wait_done_pulse();
        check_val("R3 R7 recovery read", rd_data, w2);
        repeat (3) step();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule